// File: doc/BRIEF.md
# Dual Down-Counting Timer

This peripheral holds two independent down-counters behind a plain register read/write port. Each counter advances on a step that comes from one of two sources. The first is a fixed reference tick, a one-cycle enable pulse synchronous to the bus clock. The second is the bus clock divided by a power of two, where a shift-coded field sets the divide ratio. Both timers share one control word.

When a counter is at zero on a step, it has expired. The timer then sets a sticky status bit, and that bit drives the timer's interrupt line. In periodic mode the counter then reloads from its reload register and keeps going. In one-shot mode it stays at zero and hardware clears the timer's enable bit, so the event fires once. To clear a status bit, software writes a word with a zero in that bit's position; a one leaves the bit as it is.

Loading all-ones into both the value and reload registers, with auto-reload on, gives a free-running down counter. A system typically uses one timer this way as a time base and the other as an interrupt-driven event timer.

Top module: `twin_countdown_timer`

## Requirements
- R1: After reset every register reads zero and both interrupt lines are low. The registers are control at 0x00, status at 0x04, timer 0 reload at 0x10, timer 0 value at 0x14, timer 1 reload at 0x18 and timer 1 value at 0x1C.
- R2: The control register holds the following bits. Every other control bit reads as zero.
  - bit 0: timer 0 enable.
  - bit 1: timer 0 auto-reload.
  - bit 2: timer 1 enable.
  - bit 3: timer 1 auto-reload.
  - bit 11: timer 0 reference select.
  - bit 12: timer 1 reference select.
  - bits 21:19: timer 0 prescale shift.
  - bits 24:22: timer 1 prescale shift.
  - Writing all-ones therefore reads back 0x01F8180F.
- R3: A write to a value register loads that counter directly, and a write takes priority over a step in the same cycle. Value and reload registers read back what they hold.
- R4: With the reference select clear and shift N, an enabled counter decrements once every 2^N clock cycles. The first decrement lands 2^N cycles after the enabling write.
- R5: With the reference select set, an enabled counter decrements once on every cycle in which ref_tick is high, whatever its shift field holds.
- R6: A timer expires on a step taken while its counter is zero. Expiry sets its status bit (bit 0 for timer 0, bit 8 for timer 1), so a loaded value V expires on step V+1.
- R7: With auto-reload set, the counter takes the reload value on expiry, the enable bit stays set and counting continues.
- R8: With auto-reload clear, the counter stays at zero on expiry and hardware clears the timer's enable bit in the control register. A control write in the same cycle wins over this clearing.
- R9: A status write clears each status bit written as 0 and leaves bits written as 1 unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R10: Each interrupt line follows its status bit, staying high while the bit is set even when the timer is disabled.
- R11: Clearing an enable bit freezes the counter at its value. Disabling also restarts the prescaler, so after re-enabling, the first decrement again takes 2^N cycles.
- R12: With reload 0xFFFFFFFF and auto-reload set, a counter expiring at zero continues at 0xFFFFFFFF and then 0xFFFFFFFE.
- R13: Reads of unmapped addresses return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle fixed reference step pulse |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq | output | 2 | Interrupt level per timer, bit i for timer i |

## Verification
The bench builds the block with DATA_W of 32 and PSC_W of 3, so shift fields reach 7. A divide by 128 therefore fits inside a few hundred cycles, and a random run crosses many prescaled expiries. The 32-bit counter width keeps a full wrap out of reach. The bench instead reaches the all-ones reload boundary by expiring from zero into a reload of 0xFFFFFFFF. Small random load values make expiries, reloads, one-shot stops and status clear/set collisions frequent.

// File: rtl/tct_pkg.sv
`timescale 1ns/1ps
package tct_pkg;

  localparam int NUM_CH = 2;

  // register byte addresses
  localparam int A_CTRL = 'h00;
  localparam int A_STAT = 'h04;

  function automatic int reload_addr(input int ch);
    return 'h10 + 8 * ch;
  endfunction

  function automatic int value_addr(input int ch);
    return 'h14 + 8 * ch;
  endfunction

  // control word bit layout per channel
  function automatic int en_bit(input int ch);
    return 2 * ch;
  endfunction

  function automatic int rl_bit(input int ch);
    return 2 * ch + 1;
  endfunction

  function automatic int ref_bit(input int ch);
    return 11 + ch;
  endfunction

  function automatic int psc_lsb(input int ch, input int psc_w);
    return 19 + psc_w * ch;
  endfunction

  // status bit per channel
  function automatic int st_bit(input int ch);
    return 8 * ch;
  endfunction

endpackage

// File: rtl/tct_prescale.sv
`timescale 1ns/1ps
module tct_prescale #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] shift,
  output logic             tick
);
  localparam int CW = (1 << PSC_W) - 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] mask;

  always_comb begin
    for (int b = 0; b < CW; b++) begin
      mask[b] = (b < int'(shift));
    end
    tick  = run & (&(cnt_q | ~mask));
    cnt_d = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tct_channel.sv
`timescale 1ns/1ps
module tct_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              auto_reload,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0] reload_data,
  output logic [DATA_W-1:0] count,
  output logic              expire
);
  logic [DATA_W-1:0] cnt_d;

  always_comb begin
    expire = step && (count == '0);
    cnt_d  = count;
    if (load) begin
      cnt_d = load_data;
    end else if (step) begin
      if (count == '0) cnt_d = auto_reload ? reload_data : '0;
      else             cnt_d = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end
endmodule

// File: rtl/twin_countdown_timer.sv
`timescale 1ns/1ps
module twin_countdown_timer
  import tct_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int PSC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  function automatic logic [DATA_W-1:0] ctrl_mask_f();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[en_bit(c)]  = 1'b1;
      m[rl_bit(c)]  = 1'b1;
      m[ref_bit(c)] = 1'b1;
      for (int b = 0; b < PSC_W; b++) m[psc_lsb(c, PSC_W) + b] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask_f();

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [NUM_CH-1:0] stat_q, stat_d;
  logic [NUM_CH-1:0][DATA_W-1:0] reload_q, reload_d;
  logic [NUM_CH-1:0][DATA_W-1:0] count_q;
  logic [NUM_CH-1:0] expire, step, psc_tick, wr_val, wr_rel;
  logic wr_any, wr_ctrl, wr_stat;

  assign wr_any  = bus_en & bus_we;
  assign wr_ctrl = wr_any && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_stat = wr_any && (bus_addr == ADDR_W'(A_STAT));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int EN = en_bit(i);
    localparam int RL = rl_bit(i);
    localparam int RS = ref_bit(i);
    localparam int PL = psc_lsb(i, PSC_W);

    assign wr_val[i] = wr_any && (bus_addr == ADDR_W'(value_addr(i)));
    assign wr_rel[i] = wr_any && (bus_addr == ADDR_W'(reload_addr(i)));

    tct_prescale #(.PSC_W(PSC_W)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl_q[EN]),
      .shift (ctrl_q[PL +: PSC_W]),
      .tick  (psc_tick[i])
    );

    assign step[i] = ctrl_q[EN] & (ctrl_q[RS] ? ref_tick : psc_tick[i]);

    tct_channel #(.DATA_W(DATA_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (step[i]),
      .auto_reload (ctrl_q[RL]),
      .load        (wr_val[i]),
      .load_data   (bus_wdata),
      .reload_data (reload_q[i]),
      .count       (count_q[i]),
      .expire      (expire[i])
    );
  end

  // next-state
  always_comb begin
    ctrl_d   = ctrl_q;
    stat_d   = stat_q;
    reload_d = reload_q;
    if (wr_ctrl) begin
      ctrl_d = bus_wdata & CTRL_MASK;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (expire[c] && !ctrl_q[rl_bit(c)]) ctrl_d[en_bit(c)] = 1'b0;
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (wr_stat && !bus_wdata[st_bit(c)]) stat_d[c] = 1'b0;
      if (expire[c]) stat_d[c] = 1'b1;
      if (wr_rel[c]) reload_d[c] = bus_wdata;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      stat_q   <= '0;
      reload_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      stat_q   <= stat_d;
      reload_q <= reload_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_en) begin
      if (bus_addr == ADDR_W'(A_CTRL)) bus_rdata = ctrl_q;
      if (bus_addr == ADDR_W'(A_STAT)) begin
        for (int c = 0; c < NUM_CH; c++) bus_rdata[st_bit(c)] = stat_q[c];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (bus_addr == ADDR_W'(reload_addr(c))) bus_rdata = reload_q[c];
        if (bus_addr == ADDR_W'(value_addr(c)))  bus_rdata = count_q[c];
      end
    end
  end

  assign irq = stat_q;

endmodule

// File: rtl/tct_checker.sv
`timescale 1ns/1ps
module tct_checker
  import tct_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_en,
  input logic                          bus_we,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [NUM_CH-1:0]             irq,
  input logic [DATA_W-1:0]             ctrl,
  input logic [NUM_CH-1:0]             stat,
  input logic [NUM_CH-1:0]             expire,
  input logic [NUM_CH-1:0][DATA_W-1:0] count,
  input logic [NUM_CH-1:0][DATA_W-1:0] reload,
  input logic [DATA_W-1:0]             wdata
);
  logic w_ctrl, w_stat;
  assign w_ctrl = bus_en && bus_we && (bus_addr == ADDR_W'(A_CTRL));
  assign w_stat = bus_en && bus_we && (bus_addr == ADDR_W'(A_STAT));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    logic w_val;
    assign w_val = bus_en && bus_we && (bus_addr == ADDR_W'(value_addr(i)));

    p_expire_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> stat[i]);

    p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[i] && !(w_stat && !wdata[st_bit(i)])) |=> stat[i]);

    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(expire[i]));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && ctrl[rl_bit(i)] && !w_val) |=> (count[i] == $past(reload[i])));

    p_oneshot_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && !ctrl[rl_bit(i)] && !w_val && !w_ctrl)
        |=> (!ctrl[en_bit(i)] && count[i] == '0));

    p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[en_bit(i)] && !w_val) |=> $stable(count[i]));
  end
endmodule

bind twin_countdown_timer tct_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .irq      (irq),
  .ctrl     (ctrl_q),
  .stat     (stat_q),
  .expire   (expire),
  .count    (count_q),
  .reload   (reload_q),
  .wdata    (bus_wdata)
);

// File: tb/sim_twin_countdown_timer.sv
`timescale 1ns/1ps
module sim_twin_countdown_timer;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int PSC_W  = 3;
  localparam int PCW    = (1 << PSC_W) - 1;
  localparam logic [31:0] CMASK = 32'h01F8180F; // R2 layout
  localparam logic [5:0] A_CT = 6'h00, A_ST = 6'h04, A_R0 = 6'h10,
                         A_V0 = 6'h14, A_R1 = 6'h18, A_V1 = 6'h1C;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, bus_en = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  wire  [DATA_W-1:0] bus_rdata;
  wire  [1:0]        irq;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  twin_countdown_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSC_W(PSC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference model built from the requirements
  logic [31:0] m_ctrl, m_cnt [2], m_rel [2];
  logic [1:0]  m_st;
  logic [PCW-1:0] m_psc [2];

  always @(posedge clk or negedge rst_n) begin : model
    logic [1:0] ex, tk;
    logic [31:0] nctrl;
    logic [PCW-1:0] msk;
    logic wr;
    if (!rst_n) begin
      m_ctrl = '0; m_st = '0;
      for (int i = 0; i < 2; i++) begin m_cnt[i] = '0; m_rel[i] = '0; m_psc[i] = '0; end
    end else begin
      wr = bus_en && bus_we;
      for (int i = 0; i < 2; i++) begin
        msk = '0;
        for (int b = 0; b < PCW; b++) msk[b] = (b < int'(m_ctrl[19 + 3*i +: 3]));
        tk[i] = m_ctrl[2*i] && (m_ctrl[11+i] ? ref_tick : ((m_psc[i] | ~msk) == '1));
        ex[i] = tk[i] && (m_cnt[i] == 0);
      end
      nctrl = m_ctrl;
      if (wr && bus_addr == A_CT) nctrl = bus_wdata & CMASK;
      else for (int i = 0; i < 2; i++) if (ex[i] && !m_ctrl[2*i+1]) nctrl[2*i] = 1'b0;
      for (int i = 0; i < 2; i++) begin
        m_psc[i] = m_ctrl[2*i] ? m_psc[i] + 1'b1 : '0;
        if (wr && bus_addr == A_ST && !bus_wdata[8*i]) m_st[i] = 1'b0;
        if (ex[i]) m_st[i] = 1'b1;
        if (wr && bus_addr == (i == 0 ? A_V0 : A_V1)) m_cnt[i] = bus_wdata;
        else if (tk[i]) m_cnt[i] = (m_cnt[i] == 0) ? (m_ctrl[2*i+1] ? m_rel[i] : 0) : m_cnt[i] - 1;
        if (wr && bus_addr == (i == 0 ? A_R0 : A_R1)) m_rel[i] = bus_wdata;
      end
      m_ctrl = nctrl;
    end
  end

  function automatic logic [31:0] m_read(input logic en, input logic [5:0] a);
    if (!en) return 0;
    case (a)
      A_CT: return m_ctrl;
      A_ST: return {23'b0, m_st[1], 7'b0, m_st[0]};
      A_R0: return m_rel[0];
      A_V0: return m_cnt[0];
      A_R1: return m_rel[1];
      A_V1: return m_cnt[1];
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic we, input logic [5:0] a,
                     input logic [31:0] wd, input logic rf, input string tag);
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd; ref_tick = rf;
    #1;
    chk({tag, " rdata"}, bus_rdata, m_read(en, a));
    chk({tag, " irq"}, {30'b0, irq}, {30'b0, m_st});
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] wd, input string tag);
    cyc(1'b1, 1'b1, a, wd, 1'b0, tag);
  endtask

  task automatic rd_exp(input logic [5:0] a, input logic [31:0] exp, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, 1'b0, tag);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n, input logic rf, input string tag);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 6'h0, 32'h0, rf, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [5:0] a;
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_exp(A_CT, 0, "R1"); rd_exp(A_ST, 0, "R1"); rd_exp(A_R0, 0, "R1");
    rd_exp(A_V0, 0, "R1"); rd_exp(A_R1, 0, "R1"); rd_exp(A_V1, 0, "R1");
    chk("R1 irq", {30'b0, irq}, 32'h0);

    // R2 control layout
    wr(A_CT, 32'hFFFF_FFFF, "R2"); rd_exp(A_CT, 32'h01F8180F, "R2");
    wr(A_CT, 32'h0, "R2");

    // R13 unmapped
    wr(6'h08, 32'hFFFF_FFFF, "R13"); rd_exp(6'h08, 0, "R13");
    rd_exp(A_CT, 0, "R13"); rd_exp(A_ST, 0, "R13");

    // R3 direct load and readback
    wr(A_V0, 32'h1234, "R3"); rd_exp(A_V0, 32'h1234, "R3");
    wr(A_R1, 32'hABCD, "R3"); rd_exp(A_R1, 32'hABCD, "R3");

    // R4 prescaled count, shift 2
    wr(A_V0, 5, "R4"); wr(A_CT, 32'h0010_0001, "R4");
    idle(3, 1'b0, "R4"); rd_exp(A_V0, 5, "R4"); rd_exp(A_V0, 4, "R4");
    // R11 freeze and prescaler restart
    wr(A_CT, 0, "R11"); idle(5, 1'b0, "R11"); rd_exp(A_V0, 4, "R11");
    wr(A_CT, 32'h0010_0001, "R11");
    idle(3, 1'b0, "R11"); rd_exp(A_V0, 4, "R11"); rd_exp(A_V0, 3, "R11");
    wr(A_CT, 0, "R11");

    // R5 reference tick ignores shift 7; R6 V+1 steps; R8 one-shot
    wr(A_V0, 2, "R5"); wr(A_CT, 32'h0038_0801, "R5");
    idle(2, 1'b1, "R5"); rd_exp(A_V0, 0, "R5"); rd_exp(A_ST, 0, "R6");
    idle(1, 1'b1, "R6"); rd_exp(A_ST, 32'h1, "R6");
    rd_exp(A_V0, 0, "R8"); rd_exp(A_CT, 32'h0038_0800, "R8");
    chk("R10 irq while disabled", {30'b0, irq}, 32'h1);
    idle(2, 1'b1, "R8"); rd_exp(A_V0, 0, "R8");

    // R9 write-one keeps, write-zero clears, set wins
    wr(A_ST, 32'hFFFF_FFFF, "R9"); rd_exp(A_ST, 32'h1, "R9");
    wr(A_ST, 32'hFFFF_FFFE, "R9"); rd_exp(A_ST, 0, "R9");
    chk("R10 irq low", {30'b0, irq}, 32'h0);
    wr(A_V1, 0, "R9"); wr(A_CT, 32'h1004, "R9");
    cyc(1'b1, 1'b1, A_ST, 32'h0, 1'b1, "R9");
    rd_exp(A_ST, 32'h100, "R9"); rd_exp(A_CT, 32'h1000, "R8");
    chk("R10 irq1", {30'b0, irq}, 32'h2);
    wr(A_ST, 0, "R9");

    // R7 periodic
    wr(A_R1, 1, "R7"); wr(A_V1, 1, "R7"); wr(A_CT, 32'h100C, "R7");
    idle(2, 1'b1, "R7"); rd_exp(A_ST, 32'h100, "R7"); rd_exp(A_V1, 1, "R7");
    rd_exp(A_CT, 32'h100C, "R7");
    wr(A_ST, 0, "R7"); rd_exp(A_ST, 0, "R7");
    idle(1, 1'b1, "R7"); rd_exp(A_V1, 0, "R7"); rd_exp(A_ST, 0, "R7");
    idle(1, 1'b1, "R7"); rd_exp(A_ST, 32'h100, "R7"); rd_exp(A_V1, 1, "R7");

    // R12 free-running all-ones reload
    wr(A_CT, 0, "R12"); wr(A_ST, 0, "R12");
    wr(A_R0, 32'hFFFF_FFFF, "R12"); wr(A_V0, 0, "R12"); wr(A_CT, 32'h803, "R12");
    idle(1, 1'b1, "R12"); rd_exp(A_V0, 32'hFFFF_FFFF, "R12"); rd_exp(A_ST, 1, "R12");
    idle(1, 1'b1, "R12"); rd_exp(A_V0, 32'hFFFF_FFFE, "R12");
    wr(A_CT, 0, "R12");

    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      case ($urandom % 8)
        0: a = A_CT; 1: a = A_ST; 2: a = A_R0; 3: a = A_V0;
        4: a = A_R1; 5: a = A_V1; 6: a = 6'h08; default: a = 6'h3C;
      endcase
      d = $urandom;
      if (a == A_CT && ($urandom % 2) == 0) d = d & 32'hFF67_FFFF;
      if (a == A_R0 || a == A_R1 || a == A_V0 || a == A_V1)
        d = (($urandom % 16) == 0) ? 32'hFFFF_FFFF : ($urandom % 24);
      cyc(($urandom % 4) != 0, ($urandom % 3) == 0, a, d, ($urandom % 3) == 0,
          "R6 R7 R9 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule